// File: doc/BRIEF.md
# RS-485 Driver-Enable Turnaround Timer

This block controls the direction of a half-duplex RS-485 transceiver that sits beside a UART transmitter. The driver enable comes on as soon as the transmitter reports it is busy. It stays on while characters go out. When the stop bit of the final queued character has ended, the enable is held for a programmable number of whole bit periods and then released. This lets the far end see a clean line before the bus turns around.

The hold is counted in baud ticks, not system clocks. It is taken from an 8-bit setting, so any hold from 0 to 255 bit periods is possible. The setting is captured when each turnaround begins. If a new character starts during the hold, the count is cancelled and the enable stays on without a gap. The enable can be steered to an RTS-style or a DTR-style pin, and a polarity bit chooses whether the asserted level is high or low. The pin that is not selected rests at the inactive level.

Top module: `rs485_de_timer`

## Requirements
- R1: During and after a synchronous reset, with no transmission, `de_active` is 0. With `polarity`=0, both `rts_pin` and `dtr_pin` are 0.
- R2: While idle, `de_active` goes to 1 on the first clock edge that samples `tx_busy`=1. It is therefore high one cycle after `tx_busy` is presented.
- R3: A turnaround begins in the cycle where `stop_done`=1 and `fifo_empty`=1. The enable stays 1 until exactly N pulses of `bit_tick` have occurred after that cycle, where N is the value of `hold_bits`. It falls on the edge that samples the N-th pulse.
- R4: With N=0, `de_active` falls on the edge that samples `stop_done`=1 together with `fifo_empty`=1, that is, one cycle later.
- R5: A `stop_done` pulse with `fifo_empty`=0 starts no turnaround, and `de_active` stays 1.
- R6: `tx_busy`=1 during a hold cancels the count and `de_active` stays 1 with no low cycle. The next turnaround counts a fresh full hold.
- R7: `hold_bits` is captured when a turnaround begins. Changing it during a hold does not alter that hold, and the new value applies from the next turnaround.
- R8: `pin_sel`=0 routes the enable to `rts_pin`, and `pin_sel`=1 routes it to `dtr_pin`. The unselected pin sits at the inactive level.
- R9: With `polarity`=0 the asserted pin level is 1 and the inactive level is 0. With `polarity`=1 the asserted level is 0 and the inactive level is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_busy | input | 1 | Transmitter is sending a character |
| stop_done | input | 1 | One-cycle pulse at the end of a character's stop bit |
| fifo_empty | input | 1 | No further character is queued |
| hold_bits | input | 8 | Hold after the last stop bit, in bit periods |
| pin_sel | input | 1 | 0 selects the RTS-style pin, 1 selects the DTR-style pin |
| polarity | input | 1 | 0 active-high, 1 active-low |
| de_active | output | 1 | Internal enable state, active-high |
| rts_pin | output | 1 | RTS-style direction pin |
| dtr_pin | output | 1 | DTR-style direction pin |

## Verification
One register separates every input from `de_active`. The enable rises one cycle after `tx_busy` is presented, and it falls one cycle after the N-th counted tick, or one cycle after the final stop pulse when N is 0. The pins follow `de_active` in the same cycle, with no extra register. The bench drives inputs on the falling edge and reads outputs at the next falling edge, so each read reflects the inputs of the previous cycle. It counts the ticks it has presented since the final stop pulse up to the first low enable and compares that count with the captured hold. This includes holds of 0, 1 and 255, cancelled holds and holds whose setting is changed mid-count.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;

    localparam int HOLD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_HOLD  = 2'd2
    } de_state_e;

    typedef enum logic {
        PIN_RTS = 1'b0,
        PIN_DTR = 1'b1
    } de_pin_e;

    typedef struct packed {
        logic    active_low;
        de_pin_e target;
    } de_route_t;

    // Pin level for a given enable state and polarity.
    function automatic logic pin_level(input logic enabled, input logic active_low);
        return enabled ? ~active_low : active_low;
    endfunction

endpackage

// File: rtl/de_hold_counter.sv
module de_hold_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign at_last = (cnt_q == ONE);
endmodule

// File: rtl/de_ctrl_fsm.sv
module de_ctrl_fsm
    import rs485_de_pkg::*;
#(
    parameter int CNT_W = HOLD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             tx_busy,
    input  logic             stop_done,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] hold_bits,
    input  logic             cnt_last,
    output logic             cnt_load,
    output logic             cnt_dec,
    output de_state_e        state
);
    de_state_e state_d;
    logic      final_stop;

    assign final_stop = stop_done && fifo_empty;

    always_comb begin
        state_d  = state;
        cnt_load = 1'b0;
        case (state)
            ST_IDLE: begin
                if (tx_busy) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (final_stop) begin
                    if (hold_bits == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_HOLD;
                        cnt_load = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tx_busy) state_d = ST_DRIVE;
                else if (bit_tick && cnt_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt_dec = (state == ST_HOLD) && bit_tick && !tx_busy;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end
endmodule

// File: rtl/de_pin_router.sv
module de_pin_router
    import rs485_de_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic                enabled,
    input  de_route_t           route,
    output logic [NUM_PINS-1:0] pins
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_comb begin
            if (int'(route.target) == i)
                pins[i] = pin_level(enabled, route.active_low);
            else
                pins[i] = pin_level(1'b0, route.active_low);
        end
    end
endmodule

// File: rtl/rs485_de_timer.sv
module rs485_de_timer
    import rs485_de_pkg::*;
#(
    parameter int CNT_W = HOLD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             tx_busy,
    input  logic             stop_done,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] hold_bits,
    input  logic             pin_sel,
    input  logic             polarity,
    output logic             de_active,
    output logic             rts_pin,
    output logic             dtr_pin
);
    localparam int NUM_PINS = 2;

    de_state_e           state;
    logic                cnt_load;
    logic                cnt_dec;
    logic                cnt_last;
    de_route_t           route;
    logic [NUM_PINS-1:0] pins;

    de_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .tx_busy    (tx_busy),
        .stop_done  (stop_done),
        .fifo_empty (fifo_empty),
        .hold_bits  (hold_bits),
        .cnt_last   (cnt_last),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec),
        .state      (state)
    );

    de_hold_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (hold_bits),
        .dec      (cnt_dec),
        .at_last  (cnt_last)
    );

    assign de_active    = (state != ST_IDLE);
    assign route.target = pin_sel ? PIN_DTR : PIN_RTS;
    assign route.active_low = polarity;

    de_pin_router #(.NUM_PINS(NUM_PINS)) u_route (
        .enabled (de_active),
        .route   (route),
        .pins    (pins)
    );

    assign rts_pin = pins[int'(PIN_RTS)];
    assign dtr_pin = pins[int'(PIN_DTR)];
endmodule

// File: rtl/rs485_de_checker.sv
module rs485_de_checker
    import rs485_de_pkg::*;
#(
    parameter int CNT_W = HOLD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_tick,
    input logic             tx_busy,
    input logic             stop_done,
    input logic             fifo_empty,
    input logic [CNT_W-1:0] hold_bits,
    input logic             pin_sel,
    input logic             polarity,
    input logic             de_active,
    input logic             rts_pin,
    input logic             dtr_pin,
    input de_state_e        state
);
    // R2: busy seen while idle turns the enable on
    a_r2_enable_on: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && tx_busy) |=> de_active);

    // R4: zero hold releases right after the final stop
    a_r4_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRIVE && stop_done && fifo_empty && hold_bits == '0) |=> !de_active);

    // R5: a stop with more queued keeps driving
    a_r5_queued_stop: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRIVE && stop_done && !fifo_empty) |=> de_active);

    // R3: a hold ends only on a bit tick
    a_r3_tick_only: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !bit_tick) |=> de_active);

    // R6: busy during hold returns to driving
    a_r6_cancel: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && tx_busy) |=> (state == ST_DRIVE));

    // R8: unselected pin rests at the inactive level
    a_r8_idle_pin: assert property (@(posedge clk) disable iff (rst)
        pin_sel ? (rts_pin == polarity) : (dtr_pin == polarity));

    // R9: selected pin shows the asserted level while enabled
    a_r9_level: assert property (@(posedge clk) disable iff (rst)
        de_active |-> ((pin_sel ? dtr_pin : rts_pin) != polarity));
endmodule

bind rs485_de_timer rs485_de_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .tx_busy    (tx_busy),
    .stop_done  (stop_done),
    .fifo_empty (fifo_empty),
    .hold_bits  (hold_bits),
    .pin_sel    (pin_sel),
    .polarity   (polarity),
    .de_active  (de_active),
    .rts_pin    (rts_pin),
    .dtr_pin    (dtr_pin),
    .state      (state)
);

// File: tb/tb_rs485_de_timer.sv
module tb_rs485_de_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic       bit_tick, tx_busy, stop_done, fifo_empty;
    logic [7:0] hold_bits;
    logic       pin_sel, polarity;
    logic       de_active, rts_pin, dtr_pin;

    int checks = 0;
    int fails  = 0;
    int tick_div = 0;
    int cycles = 0;
    bit timed_out = 1'b0;
    localparam int DIV = 4;
    localparam int WATCHDOG = 190000;

    always #10 clk = ~clk;

    rs485_de_timer dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_busy(tx_busy),
        .stop_done(stop_done), .fifo_empty(fifo_empty), .hold_bits(hold_bits),
        .pin_sel(pin_sel), .polarity(polarity), .de_active(de_active),
        .rts_pin(rts_pin), .dtr_pin(dtr_pin)
    );

    function automatic logic exp_pin(input logic en, input logic sel, input logic pol,
                                     input logic which);
        return (en && sel == which) ? ~pol : pol;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and present this cycle's bit tick.
    task automatic step();
        @(negedge clk);
        cycles++;
        if (cycles > WATCHDOG) timed_out = 1'b1;
        tick_div = (tick_div + 1) % DIV;
        bit_tick = (tick_div == 0);
    endtask

    task automatic check_pins(input string req);
        check(req, rts_pin, exp_pin(de_active, pin_sel, polarity, 1'b0));
        check(req, dtr_pin, exp_pin(de_active, pin_sel, polarity, 1'b1));
    endtask

    // Send nchar characters of 10 bits; the stop pulse of the last sets fifo_empty.
    task automatic send_chars(input int nchar, input bit from_idle);
        fifo_empty = (nchar == 1) ? 1'b0 : 1'b0;
        tx_busy = 1'b1;
        step();
        stop_done = 1'b0;
        if (from_idle) begin
            check("R2 enable after busy", de_active, 1);
            check_pins("R8/R9 asserted pin level");
        end
        for (int c = 0; c < nchar; c++) begin
            for (int b = 0; b < 10; b++) begin
                do step(); while (!bit_tick && !timed_out);
                stop_done = 1'b0;
                if (b == 9) begin
                    stop_done  = 1'b1;
                    fifo_empty = (c == nchar - 1);
                    tx_busy    = (c != nchar - 1);
                end
            end
            if (c != nchar - 1) begin
                step();
                stop_done = 1'b0;
                check("R5 enable kept across queued stop", de_active, 1);
            end
        end
    endtask

    // Count ticks after the final stop until the enable is seen low.
    task automatic measure(output int gap);
        gap = 0;
        forever begin
            step();
            stop_done = 1'b0;
            if (!de_active || timed_out) break;
            if (bit_tick) gap++;
        end
    endtask

    task automatic turnaround(input int hold, input int nchar, input string req);
        int gap;
        hold_bits = 8'(hold);
        send_chars(nchar, 1'b1);
        measure(gap);
        check(req, gap, hold);
        check_pins("R8/R9 released pin level");
    endtask

    initial begin
        int gap;
        int hold;
        int nchar;
        void'($urandom(32'h5A17));
        rst = 1'b1; bit_tick = 0; tx_busy = 0; stop_done = 0; fifo_empty = 1;
        hold_bits = 8'd0; pin_sel = 0; polarity = 0;
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R1 reset enable", de_active, 0);
        check("R1 reset rts", rts_pin, 0);
        check("R1 reset dtr", dtr_pin, 0);

        turnaround(0, 1, "R4 zero hold");
        turnaround(1, 1, "R3 hold 1");
        turnaround(255, 2, "R3 hold 255");
        pin_sel = 1;
        turnaround(3, 3, "R3/R8 hold 3 on dtr");
        polarity = 1;
        turnaround(2, 1, "R3/R9 active-low");
        pin_sel = 0;
        turnaround(0, 2, "R4/R9 zero hold active-low");
        polarity = 0;

        // R6: restart during hold, enable never drops
        hold_bits = 8'd20;
        send_chars(1, 1'b1);
        gap = 0;
        while (gap < 5 && !timed_out) begin
            step();
            stop_done = 1'b0;
            if (bit_tick) gap++;
            check("R6 enable held before restart", de_active, 1);
        end
        hold_bits = 8'd6;
        send_chars(1, 1'b0);
        check("R6 enable held through restart", de_active, 1);
        measure(gap);
        check("R6 fresh count after cancel", gap, 6);

        // R7: change setting mid-hold
        hold_bits = 8'd10;
        send_chars(1, 1'b1);
        gap = 0;
        forever begin
            step();
            stop_done = 1'b0;
            if (!de_active || timed_out) break;
            if (bit_tick) gap++;
            if (gap == 2) hold_bits = 8'd3;
        end
        check("R7 captured hold unaffected", gap, 10);
        turnaround(3, 1, "R7 new setting next turnaround");

        // Random turnarounds
        for (int i = 0; i < 20; i++) begin
            hold  = (i % 5 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 12));
            nchar = int'($urandom_range(1, 3));
            pin_sel  = 1'($urandom_range(0, 1));
            polarity = 1'($urandom_range(0, 1));
            turnaround(hold, nchar, "R3 random hold");
        end

        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule